// File: doc/BRIEF.md
# Dual-Port Address Collision Busy Arbiter

This block sits beside a true dual-port memory. It watches the left and right port requests and detects a collision: both ports are enabled and both present the same address. When that happens, one port keeps its access. The other port is told it is busy, and its write strobe to the array is held off. The winner is the port that was already at the shared address before the other one arrived. When both arrive in the same clock, the left port wins.

A write that busy held off is not lost. Once busy drops, the losing port's array write enable is raised for a fixed number of cycles so that the deferred write completes. This happens even if the request has been withdrawn by then.

A mode input selects master or slave operation.
- As master, the block computes busy itself and drives it on its busy outputs.
- As slave, its busy outputs stay low. Externally supplied busy inputs then do nothing except gate the writes. This lets several arrays be cascaded under one master arbiter.

Reads are never affected. Only the write enable to the array is gated.

Top module: `collision_busy_arbiter`

## Requirements
- R1: In master mode, when both enables are high and the two addresses are equal at a clock edge, one busy output is high in the cycle after that edge.
- R2: Busy clears in the cycle after the first edge at which the collision no longer holds, whether the addresses differ or either enable is low.
- R3: The port that was enabled at the shared address in the cycle before the collision began wins, and only the other port sees busy. Both busy outputs are never high together.
- R4: If neither port was at the shared address in the previous cycle, the left port wins and busy goes to the right port.
- R5: A port's array write enable equals its enable AND its write request in the same cycle, unless that port is busy. A busy port's write enable is low.
- R6: If a port requested a write at any edge while it was busy, its write enable is high for HOLD_CYCLES cycles (default 2), starting in the first cycle its busy is low, regardless of its request.
- R7: In slave mode (masterMode = 0), both busy outputs are low, and busyInLeft/busyInRight gate the matching write enable in the same cycle, as in R5 and R6.
- R8: The winning port's write enable is unaffected by the collision, and reads are never blocked: only write enables are gated.
- R9: A synchronous reset (rst high at an edge) leaves both busy outputs low, clears ownership and any deferred write, and leaves no port with a record of having been first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| masterMode | input | 1 | 1 = compute and drive busy, 0 = take busy from inputs |
| leftEn | input | 1 | Left port enable |
| leftWr | input | 1 | Left port write request |
| leftAddr | input | ADDR_W | Left port address |
| rightEn | input | 1 | Right port enable |
| rightWr | input | 1 | Right port write request |
| rightAddr | input | ADDR_W | Right port address |
| busyInLeft | input | 1 | Slave-mode busy for the left port |
| busyInRight | input | 1 | Slave-mode busy for the right port |
| busyOutLeft | output | 1 | Left port busy (master mode) |
| busyOutRight | output | 1 | Right port busy (master mode) |
| leftWe | output | 1 | Left write enable to the array |
| rightWe | output | 1 | Right write enable to the array |

## Verification
Busy outputs are registered, so each one is due one cycle after the edge that samples a collision's start or end. Write enables are combinational: they follow the request in the same cycle and the busy state already registered. A deferred write shows up in the first cycle after busy falls and lasts HOLD_CYCLES cycles.

The driver applies each stimulus on a falling edge. It queues the outputs expected for that same low phase, worked out from the requirements. The monitor compares them 1 ns later, once the combinational paths have settled and well before the next rising edge.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {OWN_NONE, OWN_LEFT, OWN_RIGHT} owner_e;

  // datapath -> control: collision facts of the current cycle
  typedef struct packed {
    logic match;
    logic leftPrior;
    logic rightPrior;
  } cmpInfo_t;

  // control -> datapath: which port is held off
  typedef struct packed {
    logic blockRight;
    logic blockLeft;
  } ctrlStrobe_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  cmpInfo_t    cmp,
  output ctrlStrobe_t strobe
);
  owner_e owner, ownerNext;

  always_comb begin
    if (!cmp.match)
      ownerNext = OWN_NONE;
    else if (owner != OWN_NONE)
      ownerNext = owner;
    else if (cmp.rightPrior && !cmp.leftPrior)
      ownerNext = OWN_RIGHT;
    else
      ownerNext = OWN_LEFT;   // left also takes the same-cycle tie
  end

  always_ff @(posedge clk) begin
    if (rst) owner <= OWN_NONE;
    else     owner <= ownerNext;
  end

  always_comb begin
    strobe.blockLeft  = (owner == OWN_RIGHT);
    strobe.blockRight = (owner == OWN_LEFT);
  end
endmodule

// File: rtl/arb_dpath.sv
module arb_dpath
  import arb_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int HOLD_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              masterMode,
  input  logic [1:0]        portEn,
  input  logic [1:0]        portWr,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic [1:0]        busyIn,
  input  ctrlStrobe_t       strobe,
  output cmpInfo_t          cmp,
  output logic [1:0]        busyOut,
  output logic [1:0]        arrayWe
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYCLES - 1);

  logic [1:0]        prevEn;
  logic [ADDR_W-1:0] prevLeftAddr, prevRightAddr;
  logic [1:0]        blocked;

  // address compare and first-arrival record
  always_ff @(posedge clk) begin
    if (rst) begin
      prevEn        <= '0;
      prevLeftAddr  <= '0;
      prevRightAddr <= '0;
    end else begin
      prevEn        <= portEn;
      prevLeftAddr  <= leftAddr;
      prevRightAddr <= rightAddr;
    end
  end

  always_comb begin
    cmp.match      = portEn[0] && portEn[1] && (leftAddr == rightAddr);
    cmp.leftPrior  = prevEn[0] && (prevLeftAddr == leftAddr);
    cmp.rightPrior = prevEn[1] && (prevRightAddr == rightAddr);
  end

  assign blocked = {strobe.blockRight, strobe.blockLeft};

  // per-port write gating with deferred completion
  for (genvar i = 0; i < 2; i++) begin : g_port
    logic             effBusy;
    logic             pending;
    logic [CNT_W-1:0] holdCnt;

    assign effBusy    = masterMode ? blocked[i] : busyIn[i];
    assign busyOut[i] = masterMode & blocked[i];
    assign arrayWe[i] = !effBusy &&
                        ((portEn[i] && portWr[i]) || pending || (holdCnt != '0));

    always_ff @(posedge clk) begin
      if (rst) begin
        pending <= 1'b0;
        holdCnt <= '0;
      end else if (effBusy) begin
        pending <= pending | (portEn[i] & portWr[i]);
        holdCnt <= '0;
      end else if (pending) begin
        pending <= 1'b0;
        holdCnt <= HOLD_LOAD;
      end else if (holdCnt != '0) begin
        holdCnt <= holdCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/collision_busy_arbiter.sv
module collision_busy_arbiter
  import arb_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int HOLD_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              masterMode,
  input  logic              leftEn,
  input  logic              leftWr,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              rightEn,
  input  logic              rightWr,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              busyInLeft,
  input  logic              busyInRight,
  output logic              busyOutLeft,
  output logic              busyOutRight,
  output logic              leftWe,
  output logic              rightWe
);
  cmpInfo_t    cmp;
  ctrlStrobe_t strobe;
  logic [1:0]  busyOut, arrayWe;

  arb_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cmp(cmp), .strobe(strobe)
  );

  arb_dpath #(.ADDR_W(ADDR_W), .HOLD_CYCLES(HOLD_CYCLES)) u_dpath (
    .clk(clk), .rst(rst), .masterMode(masterMode),
    .portEn({rightEn, leftEn}), .portWr({rightWr, leftWr}),
    .leftAddr(leftAddr), .rightAddr(rightAddr),
    .busyIn({busyInRight, busyInLeft}),
    .strobe(strobe), .cmp(cmp), .busyOut(busyOut), .arrayWe(arrayWe)
  );

  assign busyOutLeft  = busyOut[0];
  assign busyOutRight = busyOut[1];
  assign leftWe       = arrayWe[0];
  assign rightWe      = arrayWe[1];
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              masterMode,
  input logic              leftEn,
  input logic [ADDR_W-1:0] leftAddr,
  input logic              rightEn,
  input logic [ADDR_W-1:0] rightAddr,
  input logic              busyInLeft,
  input logic              busyInRight,
  input logic              busyOutLeft,
  input logic              busyOutRight,
  input logic              leftWe,
  input logic              rightWe
);
  logic bothMatch;
  assign bothMatch = leftEn && rightEn && (leftAddr == rightAddr);

  p_busy_on_match_r1: assert property (@(posedge clk) disable iff (rst)
    (masterMode && bothMatch) |=> (!masterMode || busyOutLeft || busyOutRight));

  p_release_r2: assert property (@(posedge clk) disable iff (rst)
    !bothMatch |=> (!busyOutLeft && !busyOutRight));

  p_single_loser_r3: assert property (@(posedge clk) disable iff (rst)
    !(busyOutLeft && busyOutRight));

  p_busy_gates_r5: assert property (@(posedge clk) disable iff (rst)
    (busyOutLeft |-> !leftWe) and (busyOutRight |-> !rightWe));

  p_slave_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !masterMode |-> (!busyOutLeft && !busyOutRight));

  p_slave_gates_r7: assert property (@(posedge clk) disable iff (rst)
    (!masterMode && busyInLeft |-> !leftWe) and (!masterMode && busyInRight |-> !rightWe));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!busyOutLeft && !busyOutRight));
endmodule

bind collision_busy_arbiter arb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .masterMode(masterMode),
  .leftEn(leftEn), .leftAddr(leftAddr),
  .rightEn(rightEn), .rightAddr(rightAddr),
  .busyInLeft(busyInLeft), .busyInRight(busyInRight),
  .busyOutLeft(busyOutLeft), .busyOutRight(busyOutRight),
  .leftWe(leftWe), .rightWe(rightWe)
);

// File: tb/sim_collision_busy_arbiter.sv
`timescale 1ns/100ps
module sim_collision_busy_arbiter;
  localparam int AW = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic masterMode = 1'b1;
  logic leftEn = 0, leftWr = 0, rightEn = 0, rightWr = 0;
  logic [AW-1:0] leftAddr = '0, rightAddr = '0;
  logic busyInLeft = 0, busyInRight = 0;
  logic busyOutLeft, busyOutRight, leftWe, rightWe;

  always #2.5 clk = ~clk;   // 200 MHz

  collision_busy_arbiter #(.ADDR_W(AW), .HOLD_CYCLES(2)) u0 (
    .clk(clk), .rst(rst), .masterMode(masterMode),
    .leftEn(leftEn), .leftWr(leftWr), .leftAddr(leftAddr),
    .rightEn(rightEn), .rightWr(rightWr), .rightAddr(rightAddr),
    .busyInLeft(busyInLeft), .busyInRight(busyInRight),
    .busyOutLeft(busyOutLeft), .busyOutRight(busyOutRight),
    .leftWe(leftWe), .rightWe(rightWe)
  );

  typedef struct {
    logic [3:0] exp;   // {busyL, busyR, weL, weR}
    string      tag;
  } item_t;

  item_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  task automatic step(input logic r, input logic m,
                      input logic le, input logic lw, input logic [AW-1:0] la,
                      input logic re, input logic rw, input logic [AW-1:0] ra,
                      input logic bl, input logic br,
                      input logic [3:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; masterMode = m;
    leftEn = le; leftWr = lw; leftAddr = la;
    rightEn = re; rightWr = rw; rightAddr = ra;
    busyInLeft = bl; busyInRight = br;
    it.exp = exp; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: compares in the low phase, after the drive has settled
  always @(negedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      item_t it;
      logic [3:0] act;
      it = expQ.pop_front();
      act = {busyOutLeft, busyOutRight, leftWe, rightWe};
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s: {busyL,busyR,weL,weR} actual %b expected %b", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    //    r m le lw la  re rw ra bl br  exp
    step(0,1, 0,0,0,  0,0,0,  0,0, 4'b0000, "R9 idle after reset");
    step(0,1, 1,1,5,  1,1,9,  0,0, 4'b0011, "R5 no collision writes pass");
    step(0,1, 1,1,5,  1,0,5,  0,0, 4'b0010, "R1 collision sampled, busy not yet");
    step(0,1, 1,1,5,  1,1,5,  0,0, 4'b0110, "R3 left first, right busy");
    step(0,1, 1,1,5,  1,1,5,  0,0, 4'b0110, "R8 winner write passes");
    step(0,1, 1,1,5,  1,0,7,  0,0, 4'b0110, "R2 busy holds until edge");
    step(0,1, 1,1,5,  1,0,7,  0,0, 4'b0011, "R6 deferred write cycle 1");
    step(0,1, 1,1,5,  1,0,7,  0,0, 4'b0011, "R6 deferred write cycle 2");
    step(0,1, 1,0,5,  1,0,7,  0,0, 4'b0000, "R6 deferred write ends");
    step(0,1, 0,0,0,  0,0,0,  0,0, 4'b0000, "R2 idle");
    step(0,1, 1,0,3,  1,1,3,  0,0, 4'b0001, "R4 simultaneous arrival");
    step(0,1, 1,0,3,  1,1,3,  0,0, 4'b0100, "R4 tie to left");
    step(0,1, 0,0,3,  1,1,3,  0,0, 4'b0100, "R2 winner disables");
    step(0,1, 0,0,3,  1,1,3,  0,0, 4'b0001, "R2 busy released");
    step(0,1, 0,0,0,  0,0,0,  0,0, 4'b0001, "R6 hold without request");
    step(0,1, 0,0,0,  0,0,0,  0,0, 4'b0000, "R6 hold over");
    step(0,1, 1,1,8,  1,0,2,  0,0, 4'b0010, "R5 left write");
    step(0,1, 1,1,2,  1,0,2,  0,0, 4'b0010, "R3 left arrives second");
    step(0,1, 1,1,2,  1,0,2,  0,0, 4'b1000, "R3 right first, left busy");
    step(1,1, 1,1,2,  1,0,2,  0,0, 4'b1000, "R9 reset applied");
    step(0,1, 1,1,2,  1,0,2,  0,0, 4'b0010, "R9 reset cleared busy");
    step(0,1, 1,1,2,  1,0,2,  0,0, 4'b0110, "R4 tie after reset");
    step(0,0, 1,1,2,  1,1,2,  0,0, 4'b0011, "R7 slave busy outputs low");
    step(0,0, 1,1,2,  1,1,2,  0,1, 4'b0010, "R7 slave busy input gates");
    step(0,0, 1,1,2,  1,1,2,  0,0, 4'b0011, "R6 slave release");
    step(0,0, 1,0,2,  1,0,2,  0,0, 4'b0001, "R6 slave deferred hold");
    step(0,0, 1,1,2,  1,0,2,  1,0, 4'b0000, "R7 slave left gated");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule